// File: doc/BRIEF.md
# Input Edge Timestamp Capture Timer

This block is a free-running 24-bit timer that stamps the moment a chosen edge appears on an asynchronous input pin. The reload value is built from two register inputs. An 8-bit prescale value supplies the upper bits and a 16-bit load value supplies the lower bits. In down mode the counter runs from that value to zero. In up mode it runs from zero to that value. At either end it wraps on the following cycle and keeps counting.

When the selected edge is seen while the block is enabled, the current count is copied into a capture register and a sticky event flag is raised. The flag stays set until a one-cycle clear strobe arrives. A mask bit decides whether the flag drives the interrupt line. The capture readout is a plain register output with no handshake, and a newer event simply overwrites it.

Top module: `edge_stamp_timer`

## Requirements
- R1: While rst_n is low, cap_value is 0, cap_flag is 0 and irq is 0.
- R2: While enable is 0, no edge causes a capture: cap_value and cap_flag keep their values. The counter is held at its start value, which is {prescale, load} in down mode and 0 in up mode.
- R3: In down mode (count_up = 0) with enable = 1, the counter decrements by one per clock. After reaching 0 it reloads {prescale, load} on the next clock, with prescale as bits 23:16 and load as bits 15:0.
- R4: In up mode (count_up = 1) with enable = 1, the counter increments by one per clock. Once it is at or above {prescale, load}, it returns to 0 on the next clock.
- R5: edge_sel selects the event: 2'b00 none, 2'b01 rising edge, 2'b10 falling edge, 2'b11 both edges.
- R6: A pin change that is first sampled at clock edge k is stamped at edge k+2. cap_value then holds the count the counter had after edge k+1, and cap_value and cap_flag change at that edge.
- R7: cap_flag is set by each capture and stays set until flag_clr is high at a clock edge. If a capture and flag_clr occur at the same edge, the flag is set.
- R8: irq is high exactly when cap_flag is high and irq_mask is high.
- R9: An event that arrives while cap_flag is already set overwrites cap_value with the new count.
- R10: Every pin level must be held for at least two clocks, which limits the input to one quarter of the clock rate. Under that condition, every qualifying edge produces exactly one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Enables counting and capture |
| count_up | input | 1 | 1 = count up from 0, 0 = count down from reload |
| edge_sel | input | 2 | Event select (none, rise, fall, both) |
| prescale | input | 8 | Upper 8 bits of the reload value |
| load | input | 16 | Lower 16 bits of the reload value |
| pin_async | input | 1 | Asynchronous event input |
| flag_clr | input | 1 | One-cycle strobe that clears cap_flag |
| irq_mask | input | 1 | Interrupt enable for the event flag |
| cap_value | output | 24 | Count latched at the last event |
| cap_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Masked interrupt |

## Verification
Counter state is visible only through stamps. A counter that steps wrongly or wraps at the wrong value therefore shows up as a wrong cap_value at the next event. That is two clocks after the pin change is sampled. A synchronizer with the wrong depth shifts every stamp by one count, and a single directed stamp with a hand-computed value exposes this. A flag that clears itself, or loses a set that coincides with a clear, shows on cap_flag and irq in the very next cycle. The bench compares those pins on every cycle.

// File: rtl/est_pkg.sv
package est_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_RISE = 2'b01,
    EV_FALL = 2'b10,
    EV_BOTH = 2'b11
  } ev_sel_e;
endpackage

// File: rtl/est_pin_sync.sv
module est_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_async,
  input  est_pkg::ev_sel_e  sel,
  output logic              event_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] shift_q;
  logic              prev_q;
  logic              rise, fall;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) shift_q[0] <= 1'b0;
          else        shift_q[0] <= pin_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) shift_q[i] <= 1'b0;
          else        shift_q[i] <= shift_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= shift_q[LAST];

  assign rise = shift_q[LAST] & ~prev_q;
  assign fall = ~shift_q[LAST] & prev_q;

  always_comb begin
    unique case (sel)
      est_pkg::EV_RISE: event_o = rise;
      est_pkg::EV_FALL: event_o = fall;
      est_pkg::EV_BOTH: event_o = rise | fall;
      default:          event_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/est_counter.sv
module est_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         count_up,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!enable)    cnt_q <= count_up ? '0 : reload;
    else if (count_up)   cnt_q <= (cnt_q >= reload) ? '0 : cnt_q + 1'b1;
    else                 cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/est_capture.sv
module est_capture #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] count,
  input  logic         clr,
  output logic [W-1:0] value_o,
  output logic         flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_o <= '0;
      flag_o  <= 1'b0;
    end else if (capture) begin
      value_o <= count;
      flag_o  <= 1'b1;
    end else if (clr) begin
      flag_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer #(
  parameter int PRE_W       = 8,
  parameter int LOAD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = PRE_W + LOAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              count_up,
  input  logic [1:0]        edge_sel,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [LOAD_W-1:0] load,
  input  logic              pin_async,
  input  logic              flag_clr,
  input  logic              irq_mask,
  output logic [CNT_W-1:0]  cap_value,
  output logic              cap_flag,
  output logic              irq
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count_q;
  logic             pin_event;

  assign reload = {prescale, load};

  est_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_async),
    .sel       (est_pkg::ev_sel_e'(edge_sel)),
    .event_o   (pin_event)
  );

  est_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .count_up (count_up),
    .reload   (reload),
    .count_o  (count_q)
  );

  est_capture #(.W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (pin_event & enable),
    .count   (count_q),
    .clr     (flag_clr),
    .value_o (cap_value),
    .flag_o  (cap_flag)
  );

  assign irq = cap_flag & irq_mask;
endmodule

// File: rtl/edge_stamp_timer_chk.sv
module edge_stamp_timer_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         count_up,
  input logic [W-1:0] reload,
  input logic [W-1:0] count_q,
  input logic         flag_clr,
  input logic         irq_mask,
  input logic [W-1:0] cap_value,
  input logic         cap_flag,
  input logic         irq
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (cap_value == '0 && !cap_flag && !irq));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cap_value));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !count_up && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

  // R4
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && count_up && count_q >= reload) |=> count_q == '0);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq);

  // R9
  value_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> cap_flag);
endmodule

bind edge_stamp_timer edge_stamp_timer_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .count_up  (count_up),
  .reload    (reload),
  .count_q   (count_q),
  .flag_clr  (flag_clr),
  .irq_mask  (irq_mask),
  .cap_value (cap_value),
  .cap_flag  (cap_flag),
  .irq       (irq)
);

// File: tb/sim_edge_stamp_timer.sv
module sim_edge_stamp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, count_up = 1'b0, pin_async = 1'b0;
  logic        flag_clr = 1'b0, irq_mask = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic [7:0]  prescale = 8'h00;
  logic [15:0] load = 16'h0000;
  logic [W-1:0] cap_value;
  logic        cap_flag, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_stamp_timer u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count_up(count_up),
    .edge_sel(edge_sel), .prescale(prescale), .load(load),
    .pin_async(pin_async), .flag_clr(flag_clr), .irq_mask(irq_mask),
    .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq)
  );

  // Reference model built from the requirements (R3..R7, R9)
  logic         m_s1, m_s2, m_prev, m_flag;
  logic [W-1:0] m_cnt, m_cap;

  function automatic logic [W-1:0] next_count(logic [W-1:0] c, logic en, logic up, logic [W-1:0] rl);
    if (!en)    return up ? '0 : rl;
    if (up)     return (c >= rl) ? '0 : c + 1'b1;
    return (c == '0) ? rl : c - 1'b1;
  endfunction

  function automatic logic is_event(logic cur, logic prv, logic [1:0] sel);
    return (sel[0] && cur && !prv) || (sel[1] && !cur && prv);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_flag <= 0; m_cnt <= '0; m_cap <= '0;
    end else begin
      m_s1 <= pin_async; m_s2 <= m_s1; m_prev <= m_s2;
      m_cnt <= next_count(m_cnt, enable, count_up, {prescale, load});
      if (enable && is_event(m_s2, m_prev, edge_sel)) begin
        m_cap <= m_cnt; m_flag <= 1'b1;
      end else if (flag_clr) m_flag <= 1'b0;
    end
  end

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    check({req, " cap_value"}, cap_value, m_cap);
    check({req, " cap_flag"}, W'(cap_flag), W'(m_flag));
    check("R8 irq", W'(irq), W'(m_flag & irq_mask));
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all(req);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 cap_value", cap_value, '0);
    check("R1 cap_flag", W'(cap_flag), '0);
    check("R1 irq", W'(irq), '0);
    rst_n = 1'b1;

    // R2: edges while disabled are ignored
    edge_sel = 2'b11; prescale = 8'h12; load = 16'h3456; irq_mask = 1'b1;
    for (int k = 0; k < 4; k++) begin
      pin_async = ~pin_async;
      run(4, "R2");
    end
    check("R2 flag stays low", W'(cap_flag), '0);
    check("R2 value stays zero", cap_value, '0);

    // R6 / R3: directed latency stamp, down from 0x123456
    @(negedge clk); enable = 1'b1; edge_sel = 2'b01; pin_async = 1'b0;
    repeat (10) @(negedge clk);
    pin_async = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 no stamp before k+2", W'(cap_flag), '0);
    @(negedge clk);
    check("R6 stamp value", cap_value, 24'h12344A);
    check("R6 flag set", W'(cap_flag), 24'h1);
    check("R8 irq with mask", W'(irq), 24'h1);

    // R7: sticky, then cleared
    run(5, "R7");
    check("R7 still set", W'(cap_flag), 24'h1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R7 cleared", W'(cap_flag), '0);

    // R5: falling edge selected, rising ignored
    edge_sel = 2'b10; pin_async = 1'b0; run(5, "R5 fall");
    check("R5 fall captured", W'(cap_flag), 24'h1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    pin_async = 1'b1; run(5, "R5 rise ignored");
    check("R5 rise ignored", W'(cap_flag), '0);
    edge_sel = 2'b00; pin_async = 1'b0; run(5, "R5 none");
    check("R5 none ignored", W'(cap_flag), '0);

    // R9: overwrite while flag set, R8 mask off
    edge_sel = 2'b11; irq_mask = 1'b0;
    pin_async = 1'b1; run(4, "R9");
    pin_async = 1'b0; run(4, "R9");
    check("R8 irq masked", W'(irq), '0);

    // R4: up mode with small reload to force wraps
    count_up = 1'b1; prescale = 8'h00; load = 16'h0005; irq_mask = 1'b1;
    for (int k = 0; k < 12; k++) begin
      pin_async = ~pin_async;
      run(2 + k % 3, "R4");
    end
    // R3: down mode with small reload to force wraps
    count_up = 1'b0; load = 16'h0003;
    for (int k = 0; k < 12; k++) begin
      pin_async = ~pin_async;
      run(2 + k % 2, "R3");
    end

    // R10 / R7: constrained random, pin held at least two clocks
    begin
      int hold = 2;
      for (int c = 0; c < 4000; c++) begin
        @(negedge clk);
        compare_all("R10");
        flag_clr = (($urandom % 8) == 0);
        irq_mask = (($urandom % 4) != 0);
        if (($urandom % 200) == 0) count_up = ~count_up;
        if (($urandom % 100) == 0) edge_sel = 2'($urandom);
        if (($urandom % 150) == 0) enable = ~enable;
        if (($urandom % 300) == 0) begin
          prescale = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom);
          load = 16'($urandom % 40);
        end
        hold--;
        if (hold == 0) begin
          pin_async = ~pin_async;
          hold = 2 + int'($urandom % 4);
        end
      end
    end
    finish_run();
  end
endmodule